// File: doc/BRIEF.md
# Line Loss-of-Signal Monitor with Alarm-Indication Steering

This block watches a receiver front end that reports, once per bit interval, whether a pulse above the amplitude threshold arrived. From that stream it keeps a loss-of-signal (LOS) state. It declares loss once a long enough run of empty intervals has gone by. It clears loss only after an observation window passes a pulse-density test. That window opens on a received pulse. The analog comparison, equalization and threshold hysteresis all sit upstream; only the digital per-interval strobe reaches this block.

The declare length and the clear window length depend on two controls: a line-mode bit (E1 or T1) and a criteria-select bit. The block drives a level LOS status output and a sticky interrupt that software acknowledges with a write-one-to-clear strobe. A mask gates only the interrupt line. While loss is declared, two separate enables can substitute an all-ones alarm indication. One acts on the received data toward the system, the other on the transmit data toward the line. In each case the associated clock output switches to the master reference clock.

Top module: `los_ais_ctrl`

## Requirements
- R1: After reset, `los` is 1 and `irq` is 0. All run and window counters start empty, so valid signal must be seen before `los` can fall.
- R2: While `los` is 0, `los` rises on the clock edge that samples the N-th consecutive strobed interval with `pulse_seen`=0. A strobed interval with `pulse_seen`=1 restarts the run.
- R3: While `los` is 1, a strobed pulse opens an M-interval window that counts its opening interval as interval 1. `los` falls on the edge that samples interval M if the window's pulse count is at least floor(M/8).
- R4: A window that closes with fewer than floor(M/8) pulses leaves `los` at 1, and the next window opens only on the next strobed pulse.
- R5: The lengths follow {`crit_alt`,`mode_e1`}. With {0,1}, N=M=32. With {0,0}, N=M=175. With {1,1}, N=M=2048. With {1,0}, N=M=1544.
- R6: Each LOS declaration sets a sticky interrupt flag. Reset does not set it. A cycle with `irq_clr`=1 clears it, and a declaration in the same cycle wins.
- R7: `irq` equals the flag AND NOT `irq_mask`. The mask never affects `los`.
- R8: While `los`=1 and `sys_ais_en`=1, `rx_data_out` is 1 and `rx_clk_out` follows `mclk_in`. Otherwise they follow `rx_data_in` and `rx_clk_in`.
- R9: While `los`=1 and `line_ais_en`=1, `tx_data_out` is 1 and `tx_clk_out` follows `mclk_in`. Otherwise they follow `tx_data_in` and `tx_clk_in`.
- R10: Cycles with `ival_stb`=0 are not intervals. `pulse_seen` is ignored in them, and they neither advance nor restart any run or window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ival_stb | input | 1 | Marks a cycle that carries one bit interval |
| pulse_seen | input | 1 | Pulse above threshold in this interval (valid with ival_stb) |
| mode_e1 | input | 1 | 1 = E1 line, 0 = T1 line |
| crit_alt | input | 1 | Selects the alternate declare/clear criteria |
| irq_mask | input | 1 | Suppresses the interrupt line |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| sys_ais_en | input | 1 | Enables all-ones substitution toward the system side |
| line_ais_en | input | 1 | Enables all-ones substitution toward the line side |
| mclk_in | input | 1 | Master reference clock, used as a data-level signal |
| rx_data_in | input | 1 | Received data from the recovery path |
| rx_clk_in | input | 1 | Recovered clock |
| tx_data_in | input | 1 | Transmit data from the system |
| tx_clk_in | input | 1 | Transmit clock |
| los | output | 1 | Loss-of-signal status |
| irq | output | 1 | Masked interrupt |
| rx_data_out | output | 1 | System-side data, all ones under AIS |
| rx_clk_out | output | 1 | System-side clock, master clock under AIS |
| tx_data_out | output | 1 | Line-side data, all ones under AIS |
| tx_clk_out | output | 1 | Line-side clock, master clock under AIS |

## Verification
Pulse patterns spaced every eighth interval that reach floor(M/8) exactly separate a correct density threshold from an off-by-one. A window holding one pulse fewer shows that a failed window leaves loss declared, and the delayed second window shows that it reopens only on a fresh pulse. Empty runs are broken one interval short of N by a pulse, or padded with unstrobed cycles that carry `pulse_seen`. These tell a strict consecutive count apart from one that counts cycles or ignores resets. Every mode pairing is run through both a clear and a declare, so a swapped length table shows up as a shifted edge.

// File: rtl/los_pkg.sv
package los_pkg;
  typedef logic [15:0] len_t;

  // Pick a window length from the {alternate, E1} control pair.
  function automatic len_t pick_len(input logic e1, input logic alt,
                                    input len_t e1_std, input len_t t1_std,
                                    input len_t e1_alt, input len_t t1_alt);
    case ({alt, e1})
      2'b01:   return e1_std;
      2'b00:   return t1_std;
      2'b11:   return e1_alt;
      default: return t1_alt;
    endcase
  endfunction

  // Minimum pulse count for 12.5 % density over m intervals.
  function automatic len_t density_floor(input len_t m);
    return m >> 3;
  endfunction

  function automatic logic density_met(input len_t cnt, input len_t m);
    return cnt >= density_floor(m);
  endfunction
endpackage

// File: rtl/los_decl_run.sv
module los_decl_run
  import los_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic stb,
  input  logic pulse,
  input  len_t n_len,
  output logic decl_hit
);
  len_t zcnt;

  always_comb begin
    decl_hit = arm && stb && !pulse && ((zcnt + 16'd1) >= n_len);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zcnt <= '0;
    end else if (!arm || (stb && pulse) || decl_hit) begin
      zcnt <= '0;
    end else if (stb) begin
      zcnt <= zcnt + 16'd1;
    end
  end

  // R10: an unstrobed cycle leaves the empty run untouched
  a_r10_idle_holds_run: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !stb) |=> $stable(zcnt));

  // R2: a strobed pulse restarts the run
  a_r2_pulse_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && pulse) |=> (zcnt == '0));
endmodule

// File: rtl/los_clr_win.sv
module los_clr_win
  import los_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic stb,
  input  logic pulse,
  input  len_t m_len,
  output logic clr_hit,
  output logic win_open
);
  logic open_q;
  len_t wcnt;
  len_t pcnt;
  len_t pcnt_next;
  logic win_last;

  always_comb begin
    pcnt_next = pcnt + len_t'(pulse);
    win_last  = open_q && stb && ((wcnt + 16'd1) >= m_len);
    clr_hit   = arm && win_last && density_met(pcnt_next, m_len);
    win_open  = open_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      wcnt   <= '0;
      pcnt   <= '0;
    end else if (!arm) begin
      open_q <= 1'b0;
      wcnt   <= '0;
      pcnt   <= '0;
    end else if (!open_q) begin
      if (stb && pulse) begin
        open_q <= 1'b1;
        wcnt   <= 16'd1;
        pcnt   <= 16'd1;
      end
    end else if (stb) begin
      if (win_last) begin
        open_q <= 1'b0;
        wcnt   <= '0;
        pcnt   <= '0;
      end else begin
        wcnt <= wcnt + 16'd1;
        pcnt <= pcnt_next;
      end
    end
  end

  // R3: pulses counted never exceed intervals elapsed
  a_r3_pcnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (pcnt <= wcnt));

  // R4: a window opens only on a strobed pulse
  a_r4_open_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(stb && pulse));
endmodule

// File: rtl/los_irq.sv
module los_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  input  logic mask,
  output logic irq,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  assign irq = flag & ~mask;

  // R6: the flag is sticky until acknowledged
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);

  // R7: a masked interrupt stays low
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq);
endmodule

// File: rtl/los_ais_mux.sv
module los_ais_mux (
  input  logic los,
  input  logic sys_en,
  input  logic line_en,
  input  logic mclk_in,
  input  logic rx_data_in,
  input  logic rx_clk_in,
  input  logic tx_data_in,
  input  logic tx_clk_in,
  output logic rx_data_out,
  output logic rx_clk_out,
  output logic tx_data_out,
  output logic tx_clk_out
);
  logic sys_sub;
  logic line_sub;

  always_comb begin
    sys_sub     = los & sys_en;
    line_sub    = los & line_en;
    rx_data_out = sys_sub  ? 1'b1    : rx_data_in;
    rx_clk_out  = sys_sub  ? mclk_in : rx_clk_in;
    tx_data_out = line_sub ? 1'b1    : tx_data_in;
    tx_clk_out  = line_sub ? mclk_in : tx_clk_in;
  end
endmodule

// File: rtl/los_ais_ctrl.sv
module los_ais_ctrl
  import los_pkg::*;
#(
  parameter len_t E1_STD_LEN = 16'd32,
  parameter len_t T1_STD_LEN = 16'd175,
  parameter len_t E1_ALT_LEN = 16'd2048,
  parameter len_t T1_ALT_LEN = 16'd1544
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ival_stb,
  input  logic pulse_seen,
  input  logic mode_e1,
  input  logic crit_alt,
  input  logic irq_mask,
  input  logic irq_clr,
  input  logic sys_ais_en,
  input  logic line_ais_en,
  input  logic mclk_in,
  input  logic rx_data_in,
  input  logic rx_clk_in,
  input  logic tx_data_in,
  input  logic tx_clk_in,
  output logic los,
  output logic irq,
  output logic rx_data_out,
  output logic rx_clk_out,
  output logic tx_data_out,
  output logic tx_clk_out
);
  len_t win_len;
  logic decl_hit;
  logic clr_hit;
  logic win_open;
  logic irq_flag;
  logic los_q;

  // One table serves both the declare run and the clear window (R5).
  assign win_len = pick_len(mode_e1, crit_alt, E1_STD_LEN, T1_STD_LEN,
                            E1_ALT_LEN, T1_ALT_LEN);

  los_decl_run u_decl (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (!los_q),
    .stb      (ival_stb),
    .pulse    (pulse_seen),
    .n_len    (win_len),
    .decl_hit (decl_hit)
  );

  los_clr_win u_clr (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (los_q),
    .stb      (ival_stb),
    .pulse    (pulse_seen),
    .m_len    (win_len),
    .clr_hit  (clr_hit),
    .win_open (win_open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        los_q <= 1'b1;
    else if (decl_hit) los_q <= 1'b1;
    else if (clr_hit)  los_q <= 1'b0;
  end

  assign los = los_q;

  los_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (decl_hit),
    .clr_req (irq_clr),
    .mask    (irq_mask),
    .irq     (irq),
    .flag    (irq_flag)
  );

  los_ais_mux u_ais (
    .los         (los_q),
    .sys_en      (sys_ais_en),
    .line_en     (line_ais_en),
    .mclk_in     (mclk_in),
    .rx_data_in  (rx_data_in),
    .rx_clk_in   (rx_clk_in),
    .tx_data_in  (tx_data_in),
    .tx_clk_in   (tx_clk_in),
    .rx_data_out (rx_data_out),
    .rx_clk_out  (rx_clk_out),
    .tx_data_out (tx_data_out),
    .tx_clk_out  (tx_clk_out)
  );

  // R2: declaration follows an empty strobed interval
  a_r2_declare_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_q) |-> $past(ival_stb && !pulse_seen));

  // R3: clearing happens only on a strobed interval
  a_r3_clear_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_q) |-> $past(ival_stb));

  // R4: no clear window remains open once loss is cleared
  a_r4_no_window_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !los_q |-> !win_open);

  // R6: every declaration leaves the flag set
  a_r6_irq_on_declare: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_q) |-> irq_flag);

  // R8: system-side all-ones substitution
  a_r8_sys_ais: assert property (@(posedge clk) disable iff (!rst_n)
    (los_q && sys_ais_en) |-> (rx_data_out && (rx_clk_out == mclk_in)));

  // R9: line-side all-ones substitution
  a_r9_line_ais: assert property (@(posedge clk) disable iff (!rst_n)
    (los_q && line_ais_en) |-> (tx_data_out && (tx_clk_out == mclk_in)));
endmodule

// File: tb/los_ais_ctrl_tb_top.sv
module los_ais_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ival_stb = 1'b0, pulse_seen = 1'b0, mode_e1 = 1'b1, crit_alt = 1'b0;
  logic irq_mask = 1'b0, irq_clr = 1'b0, sys_ais_en = 1'b0, line_ais_en = 1'b0;
  logic mclk_in = 1'b0, rx_data_in = 1'b0, rx_clk_in = 1'b0;
  logic tx_data_in = 1'b0, tx_clk_in = 1'b0;
  logic los, irq, rx_data_out, rx_clk_out, tx_data_out, tx_clk_out;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  los_ais_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ival_stb(ival_stb), .pulse_seen(pulse_seen),
    .mode_e1(mode_e1), .crit_alt(crit_alt), .irq_mask(irq_mask),
    .irq_clr(irq_clr), .sys_ais_en(sys_ais_en), .line_ais_en(line_ais_en),
    .mclk_in(mclk_in), .rx_data_in(rx_data_in), .rx_clk_in(rx_clk_in),
    .tx_data_in(tx_data_in), .tx_clk_in(tx_clk_in), .los(los), .irq(irq),
    .rx_data_out(rx_data_out), .rx_clk_out(rx_clk_out),
    .tx_data_out(tx_data_out), .tx_clk_out(tx_clk_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One strobed interval; outputs sampled 1 ns after the capturing edge.
  task automatic tick(input logic p);
    @(negedge clk);
    ival_stb = 1'b1;
    pulse_seen = p;
    @(posedge clk);
    #1;
    ival_stb = 1'b0;
    pulse_seen = 1'b0;
  endtask

  // Window of m intervals; pulses at every `every`-th interval, at most maxp.
  task automatic clear_window(input int m, input int every, input int maxp,
                              input logic expect_clear, input string req);
    for (int i = 0; i < m; i++) begin
      tick((i % every == 0) && (i / every < maxp));
      if (i == m - 2) check({req, " still declared before window end"}, los, 1);
    end
    check({req, " at window end"}, los, expect_clear ? 0 : 1);
  endtask

  task automatic declare_run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      tick(1'b0);
      if (i == n - 2) check({req, " not declared at N-1"}, los, 0);
    end
    check({req, " declared at N"}, los, 1);
  endtask

  task automatic t_reset;
    check("R1 los after reset", los, 1);
    check("R1 irq after reset", irq, 0);
  endtask

  task automatic t_clear_e1;
    mode_e1 = 1'b1; crit_alt = 1'b0;
    clear_window(32, 8, 4, 1'b1, "R3 E1 exact floor(M/8)");
  endtask

  task automatic t_declare_e1;
    for (int i = 0; i < 20; i++) tick(1'b0);
    tick(1'b1);
    for (int i = 0; i < 31; i++) tick(1'b0);
    check("R2 pulse restarted run", los, 0);
    tick(1'b0);
    check("R2 declared after 32 empty since pulse", los, 1);
    check("R6 irq set by declare", irq, 1);
  endtask

  task automatic t_irq;
    irq_mask = 1'b1; #1;
    check("R7 mask hides irq", irq, 0);
    check("R7 mask leaves los", los, 1);
    irq_mask = 1'b0; #1;
    check("R7 unmask shows sticky flag", irq, 1);
    @(negedge clk); irq_clr = 1'b1;
    @(posedge clk); #1; irq_clr = 1'b0;
    check("R6 irq_clr clears flag", irq, 0);
    @(posedge clk); #1;
    check("R6 flag stays clear", irq, 0);
  endtask

  task automatic t_ais_active;
    mclk_in = 1'b1; rx_clk_in = 1'b0; tx_clk_in = 1'b0;
    rx_data_in = 1'b0; tx_data_in = 1'b0;
    sys_ais_en = 1'b1; line_ais_en = 1'b0; #1;
    check("R8 rx data all ones", rx_data_out, 1);
    check("R8 rx clock is master", rx_clk_out, 1);
    check("R9 tx untouched when disabled", tx_data_out, 0);
    sys_ais_en = 1'b0; line_ais_en = 1'b1; #1;
    check("R8 rx passthrough when disabled", rx_data_out, 0);
    check("R8 rx clock passthrough", rx_clk_out, 0);
    check("R9 tx data all ones", tx_data_out, 1);
    check("R9 tx clock is master", tx_clk_out, 1);
    mclk_in = 1'b0; tx_clk_in = 1'b1; #1;
    check("R9 tx clock follows master low", tx_clk_out, 0);
    line_ais_en = 1'b0; tx_clk_in = 1'b0;
  endtask

  task automatic t_failed_window;
    clear_window(32, 8, 3, 1'b0, "R4 three pulses fail");
    for (int i = 0; i < 5; i++) tick(1'b0);
    check("R4 empty gap keeps los", los, 1);
    clear_window(32, 8, 4, 1'b1, "R4 new window from next pulse");
  endtask

  task automatic t_ais_clear;
    sys_ais_en = 1'b1; line_ais_en = 1'b1;
    mclk_in = 1'b1; rx_data_in = 1'b0; tx_data_in = 1'b0; #1;
    check("R8 no substitution when clear", rx_data_out, 0);
    check("R9 no substitution when clear", tx_clk_out, 0);
    sys_ais_en = 1'b0; line_ais_en = 1'b0; mclk_in = 1'b0;
  endtask

  task automatic t_idle;
    for (int i = 0; i < 31; i++) tick(1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ival_stb = 1'b0; pulse_seen = 1'b1;
    end
    @(posedge clk); #1; pulse_seen = 1'b0;
    check("R10 unstrobed cycles do not declare", los, 0);
    tick(1'b0);
    check("R10 unstrobed pulses did not restart run", los, 1);
  endtask

  task automatic t_t1;
    mode_e1 = 1'b0; crit_alt = 1'b0;
    clear_window(175, 8, 21, 1'b1, "R5 T1 M=175 with 21 pulses");
    declare_run(175, "R5 T1 N=175");
  endtask

  task automatic t_alt_e1;
    mode_e1 = 1'b1; crit_alt = 1'b1;
    clear_window(2048, 1, 2048, 1'b1, "R5 alt E1 M=2048");
    declare_run(2048, "R5 alt E1 N=2048");
  endtask

  task automatic t_alt_t1;
    mode_e1 = 1'b0; crit_alt = 1'b1;
    clear_window(1544, 1, 1544, 1'b1, "R5 alt T1 M=1544");
    declare_run(1544, "R5 alt T1 N=1544");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_clear_e1();
    t_declare_e1();
    t_irq();
    t_ais_active();
    t_failed_window();
    t_ais_clear();
    t_idle();
    t_t1();
    t_alt_e1();
    t_alt_t1();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule